// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block is a memory-mapped general-purpose I/O controller for 128 pins, grouped as four banks of 32. A processor reaches it through a simple strobe-based register port. Each bank has a direction mask and an output latch that is changed only through separate set-bits and clear-bits registers. Each bank also has per-pin enables for rising-edge and falling-edge capture, a sticky edge-status register that software clears by writing ones, and two alternate-function words that other logic may use.

Input pins are sampled on every bus clock. An edge is captured when the new sample differs from the previous one, the pin is an input, and capture for that direction is enabled. The per-bank status vectors, the driven outputs and the direction masks are exported as flat 128-bit vectors. Register offsets are irregular: banks 0 to 2 are interleaved at the start of the window, and bank 3 sits 0x100 higher. Read data is registered.

Top module: `pinbank_gpio`

## Requirements
- R1: After reset, every register is zero. `pin_out`, `pin_dir`, `edge_stat`, `bus_rdata` and `bus_err` are all zero.
- R2: Registers decode at these byte offsets, listed for bank 0/1/2/3:
  - level 0x000/0x004/0x008/0x100
  - direction 0x00C/0x010/0x014/0x10C
  - set 0x018/0x01C/0x020/0x118
  - clear 0x024/0x028/0x02C/0x124
  - rise enable 0x030/0x034/0x038/0x130
  - fall enable 0x03C/0x040/0x044/0x13C
  - status 0x048/0x04C/0x050/0x148
  - alt-low 0x054/0x05C/0x064/0x06C
  - alt-high 0x058/0x060/0x068/0x070

  The direction, enable and alternate-function registers read back what was written. Bank b covers pins 32b to 32b+31, and bit i is pin 32b+i.
- R3: A write to set ORs the data into the bank's output latch. A write to clear removes the written bits from it.
- R4: `pin_out` is the output latch ANDed with the direction bits. `pin_dir` equals the direction registers. A direction bit of 1 means the pin is an output.
- R5: A level read returns, per bit, the output latch where direction is 1 and the sampled input where direction is 0. The sample is the `pin_in` value captured at the previous clock edge.
- R6: A status bit is set when `pin_in` is 1, its previous sample was 0, rise enable is 1 and direction is 0. A toggling output pin never sets status.
- R7: A status bit is set when `pin_in` is 0, its previous sample was 1, fall enable is 1 and direction is 0.
- R8: Writing a status register clears the bits written as 1 and keeps those written as 0. A new edge captured in the same cycle wins over the clear.
- R9: Reading a set register returns the last value written to it. Reading a clear register returns the parameter `CLR_READ_VAL` (default 0xC1EA5EED).
- R10: Offsets 0x200 and above read as zero, ignore writes and raise no error.
- R11: An access below 0x200 that hits no register, including a non-word-aligned one, reads zero. It pulses `bus_err` high for the one cycle after the access.
- R12: `bus_rdata` updates in the cycle after a `bus_rd` strobe and holds its value when no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse for an unmapped access |
| pin_in | input | 128 | Pin input levels, already synchronised |
| pin_out | output | 128 | Driven output values |
| pin_dir | output | 128 | Direction, 1 = output |
| edge_stat | output | 128 | Edge-status bits, all banks |

## Verification
The hardest case to reach from the ports is a status clear that lands in the same cycle as a fresh edge, first on a different bit and then on the very bit being cleared. To get there, the stimulus moves `pin_in` at the same falling edge that presents the clearing write. It also first returns the pin to its idle level so that a new edge is available. Edges on pins switched to output are forced too, to show that they are ignored. Beyond these directed cases, long random runs of writes, reads, stray addresses and pin toggles are compared against a bench model.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
   localparam int NBANKS = 4;
   localparam int WINDOW = 'h200;

   typedef enum logic [3:0] {
      RK_NONE, RK_LEVEL, RK_DIR, RK_SET, RK_CLR,
      RK_RISE, RK_FALL, RK_STAT, RK_AFLO, RK_AFHI
   } reg_kind_e;

   typedef struct packed {
      reg_kind_e  kind;
      logic [1:0] bank;
      logic       in_window;
   } reg_hit_t;

   function automatic reg_kind_e kind_of(input logic [2:0] q);
      case (q)
         3'd0:    kind_of = RK_LEVEL;
         3'd1:    kind_of = RK_DIR;
         3'd2:    kind_of = RK_SET;
         3'd3:    kind_of = RK_CLR;
         3'd4:    kind_of = RK_RISE;
         3'd5:    kind_of = RK_FALL;
         3'd6:    kind_of = RK_STAT;
         default: kind_of = RK_NONE;
      endcase
   endfunction
endpackage

// File: rtl/pinbank_decode.sv
module pinbank_decode
   import pinbank_pkg::*;
#(
   parameter int AW = 12
) (
   input  logic [AW-1:0] addr,
   output reg_hit_t      hit
);
   logic [6:0] word;
   logic [6:0] rel;

   always_comb begin
      hit           = '0;
      rel           = 7'd0;
      word          = addr[8:2];
      hit.in_window = (addr < AW'(WINDOW));
      if (hit.in_window && addr[1:0] == 2'b00) begin
         if (word < 7'd21) begin
            // banks 0..2 interleaved, three words per register kind
            hit.kind = kind_of(3'(word / 7'd3));
            hit.bank = 2'(word % 7'd3);
         end else if (word < 7'd29) begin
            rel      = word - 7'd21;
            hit.kind = rel[0] ? RK_AFHI : RK_AFLO;
            hit.bank = rel[2:1];
         end else if (word >= 7'd64 && word < 7'd85) begin
            // bank 3 mirrors bank 0 slots shifted by 0x100
            rel = word - 7'd64;
            if (rel % 7'd3 == 7'd0) begin
               hit.kind = kind_of(3'(rel / 7'd3));
               hit.bank = 2'd3;
            end
         end
      end
   end
endmodule

// File: rtl/pinbank_slice.sv
module pinbank_slice
   import pinbank_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  reg_kind_e    wr_kind,
   input  logic [W-1:0] wr_data,
   input  logic [W-1:0] pin_in,
   output logic [W-1:0] out_q,
   output logic [W-1:0] dir_q,
   output logic [W-1:0] rise_q,
   output logic [W-1:0] fall_q,
   output logic [W-1:0] stat_q,
   output logic [W-1:0] setlog_q,
   output logic [W-1:0] aflo_q,
   output logic [W-1:0] afhi_q,
   output logic [W-1:0] samp_q
);
   logic [W-1:0] rise_hit, fall_hit, clr_mask;
   logic         we_set, we_clr, we_dir, we_rise, we_fall, we_stat, we_aflo, we_afhi;

   assign we_set  = wr_en && wr_kind == RK_SET;
   assign we_clr  = wr_en && wr_kind == RK_CLR;
   assign we_dir  = wr_en && wr_kind == RK_DIR;
   assign we_rise = wr_en && wr_kind == RK_RISE;
   assign we_fall = wr_en && wr_kind == RK_FALL;
   assign we_stat = wr_en && wr_kind == RK_STAT;
   assign we_aflo = wr_en && wr_kind == RK_AFLO;
   assign we_afhi = wr_en && wr_kind == RK_AFHI;

   assign rise_hit = rise_q &  pin_in & ~samp_q & ~dir_q;
   assign fall_hit = fall_q & ~pin_in &  samp_q & ~dir_q;
   assign clr_mask = we_stat ? wr_data : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q    <= '0;
         setlog_q <= '0;
      end else if (we_set) begin
         out_q    <= out_q | wr_data;
         setlog_q <= wr_data;
      end else if (we_clr) begin
         out_q    <= out_q & ~wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         rise_q <= '0;
         fall_q <= '0;
         aflo_q <= '0;
         afhi_q <= '0;
      end else begin
         if (we_dir)  dir_q  <= wr_data;
         if (we_rise) rise_q <= wr_data;
         if (we_fall) fall_q <= wr_data;
         if (we_aflo) aflo_q <= wr_data;
         if (we_afhi) afhi_q <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         samp_q <= '0;
      end else begin
         stat_q <= (stat_q & ~clr_mask) | rise_hit | fall_hit;
         samp_q <= pin_in;
      end
   end

   // R3: set bits appear in the latch, cleared bits leave it
   a_r3_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
      $past(we_set) |-> ((out_q & $past(wr_data)) == $past(wr_data)));
   a_r3_clr_lands: assert property (@(posedge clk) disable iff (!rst_n)
      $past(we_clr) |-> ((out_q & $past(wr_data)) == '0));
   // R6: no status bit newly set on a pin that was an output
   a_r6_inputs_only: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_q & ~$past(stat_q) & $past(dir_q)) == '0));
   // R8: written ones clear unless an edge arrived in the same cycle
   a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      $past(we_stat) |-> ((stat_q & $past(wr_data) & ~$past(rise_hit | fall_hit)) == '0));
endmodule

// File: rtl/pinbank_gpio.sv
module pinbank_gpio
   import pinbank_pkg::*;
#(
   parameter int              AW           = 12,
   parameter int              DW           = 32,
   parameter int              BANK_W       = 32,
   parameter logic [DW-1:0]   CLR_READ_VAL = 'hC1EA5EED,
   localparam int             NPINS        = NBANKS * BANK_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_rd,
   input  logic             bus_wr,
   input  logic [AW-1:0]    bus_addr,
   input  logic [DW-1:0]    bus_wdata,
   output logic [DW-1:0]    bus_rdata,
   output logic             bus_err,
   input  logic [NPINS-1:0] pin_in,
   output logic [NPINS-1:0] pin_out,
   output logic [NPINS-1:0] pin_dir,
   output logic [NPINS-1:0] edge_stat
);
   if (AW < 10) begin : g_bad_aw
      $error("pinbank_gpio: AW must cover the 0x200 register window");
   end
   if (BANK_W != DW) begin : g_bad_w
      $error("pinbank_gpio: BANK_W must equal DW");
   end

   reg_hit_t hit;
   logic [BANK_W-1:0] out_a    [NBANKS];
   logic [BANK_W-1:0] dir_a    [NBANKS];
   logic [BANK_W-1:0] rise_a   [NBANKS];
   logic [BANK_W-1:0] fall_a   [NBANKS];
   logic [BANK_W-1:0] stat_a   [NBANKS];
   logic [BANK_W-1:0] setlog_a [NBANKS];
   logic [BANK_W-1:0] aflo_a   [NBANKS];
   logic [BANK_W-1:0] afhi_a   [NBANKS];
   logic [BANK_W-1:0] samp_a   [NBANKS];
   logic [DW-1:0]     rd_mux;
   logic [DW-1:0]     rdata_q;
   logic              err_q;
   logic              mapped_wr;

   pinbank_decode #(.AW(AW)) u_decode (
      .addr (bus_addr),
      .hit  (hit)
   );

   assign mapped_wr = bus_wr && hit.kind != RK_NONE;

   for (genvar b = 0; b < NBANKS; b++) begin : g_bank
      pinbank_slice #(.W(BANK_W)) u_slice (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (mapped_wr && hit.bank == 2'(b)),
         .wr_kind  (hit.kind),
         .wr_data  (bus_wdata),
         .pin_in   (pin_in[b*BANK_W +: BANK_W]),
         .out_q    (out_a[b]),
         .dir_q    (dir_a[b]),
         .rise_q   (rise_a[b]),
         .fall_q   (fall_a[b]),
         .stat_q   (stat_a[b]),
         .setlog_q (setlog_a[b]),
         .aflo_q   (aflo_a[b]),
         .afhi_q   (afhi_a[b]),
         .samp_q   (samp_a[b])
      );
      assign pin_out[b*BANK_W +: BANK_W]   = out_a[b] & dir_a[b];
      assign pin_dir[b*BANK_W +: BANK_W]   = dir_a[b];
      assign edge_stat[b*BANK_W +: BANK_W] = stat_a[b];
   end

   always_comb begin
      case (hit.kind)
         RK_LEVEL: rd_mux = (out_a[hit.bank] & dir_a[hit.bank]) |
                            (samp_a[hit.bank] & ~dir_a[hit.bank]);
         RK_DIR:   rd_mux = dir_a[hit.bank];
         RK_SET:   rd_mux = setlog_a[hit.bank];
         RK_CLR:   rd_mux = CLR_READ_VAL;
         RK_RISE:  rd_mux = rise_a[hit.bank];
         RK_FALL:  rd_mux = fall_a[hit.bank];
         RK_STAT:  rd_mux = stat_a[hit.bank];
         RK_AFLO:  rd_mux = aflo_a[hit.bank];
         RK_AFHI:  rd_mux = afhi_a[hit.bank];
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
         err_q   <= 1'b0;
      end else begin
         if (bus_rd) rdata_q <= rd_mux;
         err_q <= (bus_rd || bus_wr) && hit.in_window && hit.kind == RK_NONE;
      end
   end

   assign bus_rdata = rdata_q;
   assign bus_err   = err_q;

   // R11: an error pulse only ever follows an access
   a_r11_err_after_access: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> $past(bus_rd || bus_wr));
   // R12: read data holds without a read strobe
   a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_rd) |-> $stable(bus_rdata));
   // R10: a write beyond the window leaves outputs and directions alone
   a_r10_far_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_wr && !hit.in_window) |-> ($stable(pin_dir) && $stable(pin_out)));
endmodule

// File: tb/pinbank_gpio_tb.sv
module pinbank_gpio_tb;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] CLR_VAL = 32'hC1EA5EED;

   // kind-major: level, dir, set, clr, rise, fall, stat, alt-lo, alt-hi; banks 0..3
   localparam logic [11:0] ADDR_TAB [0:35] = '{
      12'h000, 12'h004, 12'h008, 12'h100,
      12'h00C, 12'h010, 12'h014, 12'h10C,
      12'h018, 12'h01C, 12'h020, 12'h118,
      12'h024, 12'h028, 12'h02C, 12'h124,
      12'h030, 12'h034, 12'h038, 12'h130,
      12'h03C, 12'h040, 12'h044, 12'h13C,
      12'h048, 12'h04C, 12'h050, 12'h148,
      12'h054, 12'h05C, 12'h064, 12'h06C,
      12'h058, 12'h060, 12'h068, 12'h070};

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_rd = 1'b0, bus_wr = 1'b0;
   logic [11:0]  bus_addr = '0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  bus_rdata;
   logic         bus_err;
   logic [127:0] pin_in = '0;
   logic [127:0] pin_out, pin_dir, edge_stat;

   int checks = 0;
   int errors = 0;

   logic [31:0] m_out[4], m_dir[4], m_rise[4], m_fall[4], m_stat[4];
   logic [31:0] m_set[4], m_aflo[4], m_afhi[4], m_samp[4];
   logic [31:0] exp_rdata = '0;
   logic        exp_err = 1'b0;
   string       rtag = "R1";

   pinbank_gpio u_dut (
      .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_err(bus_err), .pin_in(pin_in), .pin_out(pin_out),
      .pin_dir(pin_dir), .edge_stat(edge_stat));

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input bit ok, input string tag,
                        input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // returns kind 1..9 and bank, kind 0 when nothing maps
   task automatic lookup(input logic [11:0] a, output int k, output int b);
      k = 0; b = 0;
      for (int i = 0; i < 36; i++)
         if (ADDR_TAB[i] == a) begin k = i / 4 + 1; b = i % 4; end
   endtask

   function automatic logic [31:0] model_read(input int k, input int b);
      case (k)
         1: return (m_out[b] & m_dir[b]) | (m_samp[b] & ~m_dir[b]);
         2: return m_dir[b];
         3: return m_set[b];
         4: return CLR_VAL;
         5: return m_rise[b];
         6: return m_fall[b];
         7: return m_stat[b];
         8: return m_aflo[b];
         9: return m_afhi[b];
         default: return 32'h0;
      endcase
   endfunction

   task automatic step();
      logic [31:0] n_out[4], n_dir[4], n_rise[4], n_fall[4], n_stat[4];
      logic [31:0] n_set[4], n_aflo[4], n_afhi[4], clr[4];
      logic [31:0] pins, re, fe;
      logic [127:0] e_out, e_dir, e_stat;
      int k, b;
      for (int i = 0; i < 4; i++) begin
         n_out[i] = m_out[i]; n_dir[i] = m_dir[i]; n_rise[i] = m_rise[i];
         n_fall[i] = m_fall[i]; n_set[i] = m_set[i]; n_aflo[i] = m_aflo[i];
         n_afhi[i] = m_afhi[i]; clr[i] = '0;
      end
      lookup(bus_addr, k, b);
      if (bus_rd) begin
         exp_rdata = model_read(k, b);
         if (bus_addr >= 12'h200) rtag = "R10";
         else if (k == 0)         rtag = "R11";
         else if (k == 3 || k == 4) rtag = "R9";
         else if (k == 1)         rtag = "R5";
         else                     rtag = "R2";
      end else rtag = "R12";
      exp_err = (bus_rd || bus_wr) && bus_addr < 12'h200 && k == 0;
      if (bus_wr && k != 0) begin
         case (k)
            2: n_dir[b]  = bus_wdata;
            3: begin n_out[b] = m_out[b] | bus_wdata; n_set[b] = bus_wdata; end
            4: n_out[b]  = m_out[b] & ~bus_wdata;
            5: n_rise[b] = bus_wdata;
            6: n_fall[b] = bus_wdata;
            7: clr[b]    = bus_wdata;
            8: n_aflo[b] = bus_wdata;
            9: n_afhi[b] = bus_wdata;
            default: ;
         endcase
      end
      for (int i = 0; i < 4; i++) begin
         pins = pin_in[i*32 +: 32];
         re = m_rise[i] &  pins & ~m_samp[i] & ~m_dir[i];
         fe = m_fall[i] & ~pins &  m_samp[i] & ~m_dir[i];
         n_stat[i] = (m_stat[i] & ~clr[i]) | re | fe;
      end
      @(posedge clk);
      for (int i = 0; i < 4; i++) begin
         m_samp[i] = pin_in[i*32 +: 32];
         m_out[i] = n_out[i]; m_dir[i] = n_dir[i]; m_rise[i] = n_rise[i];
         m_fall[i] = n_fall[i]; m_stat[i] = n_stat[i]; m_set[i] = n_set[i];
         m_aflo[i] = n_aflo[i]; m_afhi[i] = n_afhi[i];
      end
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
         e_out[i*32 +: 32]  = m_out[i] & m_dir[i];
         e_dir[i*32 +: 32]  = m_dir[i];
         e_stat[i*32 +: 32] = m_stat[i];
      end
      check(pin_out === e_out, "R4 pin_out", pin_out, e_out);
      check(pin_dir === e_dir, "R4 pin_dir", pin_dir, e_dir);
      check(edge_stat === e_stat, "R6 edge_stat", edge_stat, e_stat);
      check(bus_rdata === exp_rdata, rtag, {96'h0, bus_rdata}, {96'h0, exp_rdata});
      check(bus_err === exp_err, "R11 bus_err", {127'h0, bus_err}, {127'h0, exp_err});
   endtask

   task automatic op(input bit rd, input bit wr, input logic [11:0] a, input logic [31:0] d);
      bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
      step();
      bus_rd = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd7719));
      for (int i = 0; i < 4; i++) begin
         m_out[i] = '0; m_dir[i] = '0; m_rise[i] = '0; m_fall[i] = '0; m_stat[i] = '0;
         m_set[i] = '0; m_aflo[i] = '0; m_afhi[i] = '0; m_samp[i] = '0;
      end
      repeat (3) @(negedge clk);
      // R1: reset state
      check(pin_out == '0 && pin_dir == '0 && edge_stat == '0, "R1 outputs", pin_out | pin_dir | edge_stat, '0);
      check(bus_rdata == '0 && bus_err == 1'b0, "R1 bus", {96'h0, bus_rdata}, '0);
      rst_n = 1'b1;
      idle(2);
      op(1, 0, 12'h00C, '0);
      check(bus_rdata == 32'h0, "R1 dir readback", {96'h0, bus_rdata}, '0);

      // R3 / R4: set and clear
      op(0, 1, 12'h00C, 32'h0000FFFF);
      op(0, 1, 12'h018, 32'hFF00FF00);
      check(pin_out[31:0] == 32'h0000FF00, "R3 set", {96'h0, pin_out[31:0]}, 128'h0000FF00);
      op(0, 1, 12'h024, 32'h00000F00);
      check(pin_out[31:0] == 32'h0000F000, "R3 clear", {96'h0, pin_out[31:0]}, 128'h0000F000);
      op(1, 0, 12'h018, '0);
      check(bus_rdata == 32'hFF00FF00, "R9 set readback", {96'h0, bus_rdata}, 128'hFF00FF00);
      op(1, 0, 12'h024, '0);
      check(bus_rdata == CLR_VAL, "R9 clear readback", {96'h0, bus_rdata}, {96'h0, CLR_VAL});
      idle(1);
      check(bus_rdata == CLR_VAL, "R12 hold", {96'h0, bus_rdata}, {96'h0, CLR_VAL});

      // R2: bank 3 at +0x100
      op(0, 1, 12'h10C, 32'h1);
      op(0, 1, 12'h118, 32'h1);
      check(pin_out[96] == 1'b1, "R2 bank3", {127'h0, pin_out[96]}, 128'h1);

      // R6: rising edges, input only
      op(0, 1, 12'h034, 32'hFFFFFFFF);
      pin_in[37] = 1'b1; idle(1);
      check(edge_stat[37] == 1'b1, "R6 rise", {127'h0, edge_stat[37]}, 128'h1);
      op(0, 1, 12'h010, 32'h00000040);
      pin_in[38] = 1'b1; idle(1);
      check(edge_stat[38] == 1'b0, "R6 output pin", {127'h0, edge_stat[38]}, 128'h0);

      // R7: falling edge
      op(0, 1, 12'h044, 32'h1);
      pin_in[64] = 1'b1; idle(1);
      check(edge_stat[64] == 1'b0, "R7 no rise enable", {127'h0, edge_stat[64]}, 128'h0);
      pin_in[64] = 1'b0; idle(1);
      check(edge_stat[64] == 1'b1, "R7 fall", {127'h0, edge_stat[64]}, 128'h1);

      // R8: clear racing a new edge
      pin_in[39] = 1'b1;
      op(0, 1, 12'h04C, 32'h00000020);
      check(edge_stat[37] == 1'b0 && edge_stat[39] == 1'b1, "R8 clear other bit",
            {126'h0, edge_stat[39], edge_stat[37]}, 128'h2);
      pin_in[37] = 1'b0; idle(1);
      pin_in[37] = 1'b1;
      op(0, 1, 12'h04C, 32'h00000020);
      check(edge_stat[37] == 1'b1, "R8 edge wins", {127'h0, edge_stat[37]}, 128'h1);

      // R5: merged level read
      pin_in[31:0] = 32'hABCD1234; idle(1);
      op(1, 0, 12'h000, '0);
      check(bus_rdata == 32'hABCDF000, "R5 level", {96'h0, bus_rdata}, 128'hABCDF000);

      // R10: beyond the window
      op(0, 1, 12'h20C, 32'hFFFFFFFF);
      check(pin_dir[31:0] == 32'h0000FFFF, "R10 write ignored", {96'h0, pin_dir[31:0]}, 128'hFFFF);
      op(1, 0, 12'h300, '0);
      check(bus_rdata == '0 && !bus_err, "R10 read zero", {95'h0, bus_err, bus_rdata}, '0);

      // R11: holes in the map
      op(1, 0, 12'h074, '0);
      check(bus_err == 1'b1 && bus_rdata == '0, "R11 hole read", {95'h0, bus_err, bus_rdata}, {95'h0, 1'b1, 32'h0});
      idle(1);
      check(bus_err == 1'b0, "R11 one cycle", {127'h0, bus_err}, '0);
      op(0, 1, 12'h002, 32'h1);
      check(bus_err == 1'b1, "R11 unaligned", {127'h0, bus_err}, 128'h1);

      // R2: alternate-function words
      op(0, 1, 12'h064, 32'h12345678);
      op(1, 0, 12'h064, '0);
      check(bus_rdata == 32'h12345678, "R2 alt low", {96'h0, bus_rdata}, 128'h12345678);
      op(1, 0, 12'h068, '0);
      check(bus_rdata == 32'h0, "R2 alt high", {96'h0, bus_rdata}, '0);

      // random phase, checked against the model in step()
      for (int n = 0; n < 4000; n++) begin
         int r;
         r = int'($urandom % 100);
         if ($urandom % 3 == 0) pin_in[$urandom % 128] ^= 1'b1;
         if (r < 40)      op(0, 1, ADDR_TAB[$urandom % 36], $urandom);
         else if (r < 70) op(1, 0, ADDR_TAB[$urandom % 36], '0);
         else if (r < 85) op(($urandom % 2) == 0, 0, 12'($urandom % 1024), $urandom);
         else if (r < 90) op(0, 1, 12'($urandom % 1024), $urandom);
         else             idle(1);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule